// File: doc/BRIEF.md
# Watchdog Down-Counter on a Shared Timebase Prescaler

This block is a system watchdog. Its down-counter is not stepped by the processor clock. It advances on a slow tick taken from a free-running prescaler, and that prescaler is also a shared timebase for other clock consumers in the chip. A two-bit timebase select chooses one tap of the prescaler. A divide-by-4 stage follows the tap, and its output is the tick. With the default width and the slowest timebase, the tick period is 16384 input clocks.

Software writes the count and an enable flag in a single write strobe. Writing again reloads the count, which keeps the watchdog from expiring. Once the watchdog is enabled, no write can turn it off. The prescaler is never cleared by a write, so the first tick after a write comes after an unknown fraction of a tick period. For this reason the timeout is a window rather than an exact value. If the counter is stepped while it holds zero, the block raises a one-cycle reset request.

Top module: `wdg_timebase_watchdog`

## Requirements
- R1: After reset the prescaler is zero, the count is zero, the watchdog is disabled and the reset request is low.
- R2: While disabled, the counter holds its value and no reset request is raised, whatever the ticks do.
- R3: Once enabled, the watchdog stays enabled. A later write with the enable flag at 0 still loads the count, but it does not disable the watchdog.
- R4: The tick period is P = 2^(PRESC_W-1+tb_i) input clocks. tb_i=3 is the slowest timebase, giving 16384 at the default PRESC_W=12. If tb_i is held constant from reset, the ticks fall on the clock edges whose count since reset is a multiple of P.
- R5: A write does not disturb the prescaler. The first tick after a write is the first multiple of P strictly after the write edge. A tick on the write edge itself is lost, because the write takes priority.
- R6: With a loaded count N, the reset request appears between N*P+1 and (N+1)*P edges after the write edge.
- R7: The reset request is a single-cycle pulse, raised on the tick that finds the count at zero. The counter then wraps to all ones and keeps counting, so the next request follows 2^CNT_W ticks later.
- R8: A write while enabled reloads the count. The timeout window then restarts from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock that feeds the prescaler |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_i | input | 2 | Timebase select; higher values give slower ticks |
| wr_en_i | input | 1 | Control write strobe |
| wr_cnt_i | input | CNT_W | Count to load |
| wr_act_i | input | 1 | Enable flag; 1 enables the watchdog, 0 has no effect on the enable |
| cnt_o | output | CNT_W | Current count |
| active_o | output | 1 | Watchdog is enabled |
| rst_req_o | output | 1 | Single-cycle reset request on expiry |

## Verification
The bench writes the control register at many prescaler phases: just before a tick, exactly on a tick edge, and just after one. It checks the exact expiry edge and also checks that the timeout stays inside the min/max window. A design that cleared the prescaler on a write would always produce the maximum timeout and would fail the exact-edge checks. A design that let a coincident tick step the freshly loaded count would expire one period early. Further checks cover the enable: a stray write with the enable flag at 0 must not disable the watchdog, and a disabled counter loaded with zero must never fire. The bench also confirms that the count wraps after expiry, so that a missing reload, or a request held high for more than one cycle, is reported.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int TB_W   = 2;
  localparam int NUM_TB = 1 << TB_W;
  localparam int DIV_W  = 2;  // divide-by-4 stage after the tap
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRESC_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [wdg_pkg::TB_W-1:0] tb_i,
  output logic                    tick_o
);
  import wdg_pkg::*;
  localparam int TAP_BASE = PRESC_W - NUM_TB;

  logic [PRESC_W-1:0] pre_q;
  logic [PRESC_W-1:0] ones;
  logic [NUM_TB-1:0]  tap_carry;
  logic [DIV_W-1:0]   div_q;
  logic               carry;

  // ones[i]: bits [i:0] all set, i.e. bit i+1 toggles next edge
  assign ones[0] = pre_q[0];
  for (genvar i = 1; i < PRESC_W; i++) begin : g_ones
    assign ones[i] = ones[i-1] & pre_q[i];
  end

  for (genvar g = 0; g < NUM_TB; g++) begin : g_tap
    assign tap_carry[g] = ones[TAP_BASE+g];
  end

  assign carry  = tap_carry[tb_i];
  assign tick_o = carry & (&div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (carry) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             wr_act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (wr_en_i) begin
        cnt_q <= wr_cnt_i;
        act_q <= act_q | wr_act_i;  // sticky enable
      end else if (act_q && tick_i) begin
        if (cnt_q == '0) begin
          cnt_q <= '1;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign active_o  = act_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdg_timebase_watchdog.sv
module wdg_timebase_watchdog #(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [wdg_pkg::TB_W-1:0] tb_i,
  input  logic                     wr_en_i,
  input  logic [CNT_W-1:0]         wr_cnt_i,
  input  logic                     wr_act_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     active_o,
  output logic                     rst_req_o
);
  logic tick;

  wdg_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tb_i   (tb_i),
    .tick_o (tick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_en_i   (wr_en_i),
    .wr_cnt_i  (wr_cnt_i),
    .wr_act_i  (wr_act_i),
    .cnt_o     (cnt_o),
    .active_o  (active_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdg_timebase_watchdog_chk.sv
module wdg_timebase_watchdog_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             active_o,
  input logic             rst_req_o
);
  // R2
  no_req_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !rst_req_o);
  // R2
  idle_count_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !wr_en_i) |=> $stable(cnt_o));
  // R3
  enable_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> active_o);
  // R7
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R7
  req_wraps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> (cnt_o == '1));
  // R4
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1));
endmodule

bind wdg_timebase_watchdog wdg_timebase_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .cnt_o     (cnt_o),
  .active_o  (active_o),
  .rst_req_o (rst_req_o)
);

// File: tb/wdg_timebase_watchdog_tb.sv
`timescale 1ns/1ps
module wdg_timebase_watchdog_tb;
  localparam int PW = 6;
  localparam int CW = 6;
  localparam int NV = 8;
  // {delay[11:0], cnt[5:0], tb[1:0]}
  localparam logic [19:0] VEC [NV] = '{
    {12'd5,   6'd3,  2'd0},
    {12'd31,  6'd0,  2'd0},
    {12'd100, 6'd10, 2'd1},
    {12'd17,  6'd1,  2'd2},
    {12'd250, 6'd2,  2'd3},
    {12'd63,  6'd7,  2'd1},
    {12'd0,   6'd0,  2'd3},
    {12'd200, 6'd5,  2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    tb = 2'd0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_cnt = '0;
  logic          wr_act = 1'b0;
  logic [CW-1:0] cnt_o;
  logic          active_o;
  logic          rst_req_o;

  int n_chk = 0;
  int n_fail = 0;
  int ecount = 0;
  int wd = 0;

  always #4 clk = ~clk;

  wdg_timebase_watchdog #(.PRESC_W(PW), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tb_i(tb), .wr_en_i(wr_en),
    .wr_cnt_i(wr_cnt), .wr_act_i(wr_act), .cnt_o(cnt_o),
    .active_o(active_o), .rst_req_o(rst_req_o)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) ecount <= 0; else ecount <= ecount + 1;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int period(input int t);
    return 1 << (PW - 1 + t);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_write(input int c, input bit a, output int k);
    wr_cnt = c[CW-1:0]; wr_act = a; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_act = 1'b0;
    k = ecount;
  endtask

  task automatic wait_req(input int lim, output int e);
    e = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rst_req_o) begin e = ecount; break; end
    end
  endtask

  initial begin
    int k, e, p, nm, exp_e, k2;
    // R1 reset state
    #1;
    check(!rst_req_o && !active_o && cnt_o == 0, "R1 reset", {active_o, rst_req_o, cnt_o}, 0);
    do_reset();

    // vector walk: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int dly, c;
      dly = int'(VEC[v][19:8]); c = int'(VEC[v][7:2]); tb = VEC[v][1:0];
      do_reset();
      repeat (dly) @(negedge clk);
      do_write(c, 1'b1, k);
      p = period(tb);
      nm = (k / p + 1) * p;
      exp_e = nm + c * p;
      wait_req((c + 2) * p + 4, e);
      check(e == exp_e, "R5 exact expiry edge", e, exp_e);
      check(e - k >= c * p + 1 && e - k <= (c + 1) * p, "R6 timeout window", e - k, (c + 1) * p);
    end

    // R2: disabled counter holding zero never fires
    do_reset(); tb = 2'd0;
    do_write(0, 1'b0, k);
    wait_req(600, e);
    check(e == -1, "R2 no request while disabled", e, -1);
    check(cnt_o == 0 && !active_o, "R2 count frozen", cnt_o, 0);

    // R3 sticky enable, R7 wrap and pulse
    do_reset(); tb = 2'd0; p = period(0);
    do_write(3, 1'b1, k);
    repeat (5) @(negedge clk);
    do_write(3, 1'b0, k);
    check(active_o == 1'b1, "R3 enable kept", active_o, 1);
    wait_req(10 * p, e);
    exp_e = (k / p + 1) * p + 3 * p;
    check(e == exp_e, "R3 expiry after disable attempt", e, exp_e);
    @(negedge clk);
    check(!rst_req_o, "R7 single-cycle pulse", rst_req_o, 0);
    check(cnt_o == (1 << CW) - 1, "R7 wrap to all ones", cnt_o, (1 << CW) - 1);
    k2 = e;
    wait_req(((1 << CW) + 2) * p, e);
    check(e == k2 + (1 << CW) * p, "R7 second expiry", e, k2 + (1 << CW) * p);

    // R8 reload restarts window
    do_reset(); tb = 2'd1; p = period(1);
    do_write(2, 1'b1, k);
    repeat (2 * p) @(negedge clk);
    do_write(2, 1'b0, k2);
    wait_req(5 * p, e);
    exp_e = (k2 / p + 1) * p + 2 * p;
    check(e == exp_e, "R8 reload restarts", e, exp_e);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule